// File: doc/BRIEF.md
# Spike Fanout and Delayed Dendritic Accumulator

This block receives spike events one at a time, each naming a source axon, and turns each event into weighted contributions for the neurons that axon feeds. A per-axon map gives the start address and length of a list in synapse storage. Each list entry names a destination neuron, a signed weight and a delay of a few timesteps. The block walks the list at one entry per cycle and adds each weight into an accumulator for that neuron. Events are handled in arrival order and only as they occur; the block never works through a dense vector of all input activations.

Each neuron has a ring of delay slots, so a weight with a nonzero delay lands in a future timestep's total. A timestep pulse advances the ring. A separate neuron-update stage drains the current timestep's totals through a request/response read port. Accumulation and neuron update share nothing except the accumulator storage. Both maps are loaded through simple write ports before traffic starts.

Top module: `spike_fanout_accum`

## Requirements
- R1: `spk_ready` is high when no list is being walked. A spike accepted (`spk_valid` and `spk_ready` high at a clock edge) whose axon has a nonzero count N holds `spk_ready` low for exactly the next N cycles. A spike whose axon has count zero leaves `spk_ready` high.
- R2: For a spike on axon `a` with map entry (base B, count N), synapse entries B, B+1, ... B+N-1 are applied in that order, one per cycle. Addresses wrap modulo 1024.
- R3: With current slot index C (0..7), an entry (neuron n, weight w, delay d) adds w into neuron n's slot (C+d) mod 8.
- R4: Every accumulator total and every returned read value saturates to the signed 16-bit range [-32768, 32767].
- R5: `rd_en` with `rd_neuron` = n returns, on the next cycle with `rd_valid` high, neuron n's total in slot C. That entry is then zero. `rd_valid` is low in the cycle after any cycle without `rd_en`.
- R6: A read and an accumulation that target the same neuron and slot C in the same cycle, with no `tick`, return the stored total plus the weight. The entry is left at zero, so the contribution is neither lost nor counted twice.
- R7: `tick` advances C by one modulo 8 and zeroes every neuron's entry in the slot it leaves. A read in the same cycle returns that slot's total from before the clear.
- R8: An accumulation in a `tick` cycle is placed relative to the advanced index, at slot (C+1+d) mod 8. With d = 7 it lands in the slot being cleared, and that entry holds just the weight.
- R9: After reset, C = 0, all totals are zero, `spk_ready` is high, `rd_valid` is low and every axon count is zero.
- R10: Map writes through the configuration ports take effect for spikes accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spk_valid | input | 1 | Spike event offered |
| spk_ready | output | 1 | Block can take a spike |
| spk_axon | input | 8 | Source axon of the offered spike |
| tick | input | 1 | Timestep advance pulse |
| rd_en | input | 1 | Drain request for one neuron |
| rd_neuron | input | 8 | Neuron to drain from the current slot |
| rd_valid | output | 1 | Drain response valid |
| rd_data | output | 16 | Drained total, signed |
| ax_we | input | 1 | Axon map write enable |
| ax_waddr | input | 8 | Axon map write address |
| ax_wbase | input | 10 | First synapse address of the list |
| ax_wcount | input | 11 | Number of list entries |
| syn_we | input | 1 | Synapse entry write enable |
| syn_waddr | input | 10 | Synapse entry address |
| syn_wneuron | input | 8 | Destination neuron |
| syn_wweight | input | 8 | Signed weight |
| syn_wdelay | input | 3 | Delay in timesteps |

## Verification
Three activities can hit the same accumulator entry in one cycle: the list walker adding a weight, the drain port reading and clearing, and the timestep pulse clearing a whole slot. The bench aligns a drain request with the single cycle in which a one-entry list applies its weight, and it raises `tick` in the cycle in which a delay-7 or delay-0 entry is applied. It then judges the drained value, a second drain of the same entry, and the value that reappears after the ring has gone fully around. A behavioural model that applies the read, the clear and the add in sequence predicts every response on every clock.

// File: rtl/sfa_pkg.sv
// Package: default geometry of the fanout/accumulator block and the list
// walker state encoding. Assumes all widths are small enough for flop storage.
package sfa_pkg;
    parameter int unsigned SFA_AXON_W = 8;   // axon id width
    parameter int unsigned SFA_SYN_AW = 10;  // synapse storage address width
    parameter int unsigned SFA_NRN_W  = 8;   // neuron index width
    parameter int unsigned SFA_WGT_W  = 8;   // signed weight width
    parameter int unsigned SFA_DLY_W  = 3;   // delay width (ring of 2**DLY_W slots)
    parameter int unsigned SFA_ACC_W  = 16;  // signed accumulator width

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;
endpackage

// File: rtl/sfa_axon_table.sv
// Axon map: one (base, count) pair per axon id. Written one entry per cycle
// through the configuration port and read combinationally by the walker.
// Assumes writes are not issued in the cycle a spike is accepted.
module sfa_axon_table #(
    parameter int unsigned AXON_W = 8,
    parameter int unsigned SYN_AW = 10,
    parameter int unsigned CNT_W  = SYN_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AXON_W-1:0] wr_addr,
    input  logic [SYN_AW-1:0] wr_base,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic [AXON_W-1:0] rd_addr,
    output logic [SYN_AW-1:0] rd_base,
    output logic [CNT_W-1:0]  rd_count
);
    localparam int unsigned NUM_AXONS = 1 << AXON_W;

    logic [SYN_AW-1:0] base_q [NUM_AXONS];
    logic [CNT_W-1:0]  cnt_q  [NUM_AXONS];

    // Purpose: hold the map; reset empties every list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AXONS; i++) begin
                base_q[AXON_W'(i)] <= '0;
                cnt_q[AXON_W'(i)]  <= '0;
            end
        end else if (wr_en) begin
            base_q[wr_addr] <= wr_base;
            cnt_q[wr_addr]  <= wr_count;
        end
    end

    // Purpose: lookup for the offered spike.
    always_comb begin
        rd_base  = base_q[rd_addr];
        rd_count = cnt_q[rd_addr];
    end
endmodule

// File: rtl/sfa_syn_mem.sv
// Synapse storage: each entry is (neuron, signed weight, delay). Written
// through the configuration port, read combinationally at the walk pointer.
// Assumes entries are written before any spike uses them.
module sfa_syn_mem #(
    parameter int unsigned SYN_AW = 10,
    parameter int unsigned NRN_W  = 8,
    parameter int unsigned WGT_W  = 8,
    parameter int unsigned DLY_W  = 3
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [SYN_AW-1:0]       wr_addr,
    input  logic [NRN_W-1:0]        wr_neuron,
    input  logic signed [WGT_W-1:0] wr_weight,
    input  logic [DLY_W-1:0]        wr_delay,
    input  logic [SYN_AW-1:0]       rd_addr,
    output logic [NRN_W-1:0]        rd_neuron,
    output logic signed [WGT_W-1:0] rd_weight,
    output logic [DLY_W-1:0]        rd_delay
);
    localparam int unsigned DEPTH = 1 << SYN_AW;

    logic [NRN_W-1:0]        nrn_q [DEPTH];
    logic signed [WGT_W-1:0] wgt_q [DEPTH];
    logic [DLY_W-1:0]        dly_q [DEPTH];

    // Purpose: store one synapse entry per write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            nrn_q[wr_addr] <= wr_neuron;
            wgt_q[wr_addr] <= wr_weight;
            dly_q[wr_addr] <= wr_delay;
        end
    end

    // Purpose: present the entry at the walk pointer.
    always_comb begin
        rd_neuron = nrn_q[rd_addr];
        rd_weight = wgt_q[rd_addr];
        rd_delay  = dly_q[rd_addr];
    end
endmodule

// File: rtl/sfa_fanout_walker.sv
// Fanout walker: accepts one spike, looks up its list and issues one
// accumulation per cycle until the list is exhausted. Ready is low while
// walking. A zero-length list is consumed without leaving idle.
module sfa_fanout_walker
    import sfa_pkg::*;
#(
    parameter int unsigned AXON_W = 8,
    parameter int unsigned SYN_AW = 10,
    parameter int unsigned CNT_W  = SYN_AW + 1,
    parameter int unsigned NRN_W  = 8,
    parameter int unsigned WGT_W  = 8,
    parameter int unsigned DLY_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spk_valid,
    input  logic [AXON_W-1:0]       spk_axon,
    output logic                    spk_ready,
    output logic [AXON_W-1:0]       map_addr,
    input  logic [SYN_AW-1:0]       map_base,
    input  logic [CNT_W-1:0]        map_count,
    output logic [SYN_AW-1:0]       syn_addr,
    input  logic [NRN_W-1:0]        syn_neuron,
    input  logic signed [WGT_W-1:0] syn_weight,
    input  logic [DLY_W-1:0]        syn_delay,
    output logic                    acc_valid,
    output logic [NRN_W-1:0]        acc_neuron,
    output logic signed [WGT_W-1:0] acc_weight,
    output logic [DLY_W-1:0]        acc_delay
);
    walk_state_e       state_q;
    logic [SYN_AW-1:0] ptr_q;
    logic [CNT_W-1:0]  rem_q;

    // Purpose: step through the list of the accepted spike.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
            ptr_q   <= '0;
            rem_q   <= '0;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    if (spk_valid && (map_count != '0)) begin
                        ptr_q   <= map_base;
                        rem_q   <= map_count;
                        state_q <= WALK_BUSY;
                    end
                end
                WALK_BUSY: begin
                    ptr_q <= ptr_q + 1'b1;
                    rem_q <= rem_q - 1'b1;
                    if (rem_q == CNT_W'(1)) begin
                        state_q <= WALK_IDLE;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    // Purpose: handshake, lookup addresses and the issued accumulation.
    always_comb begin
        spk_ready  = (state_q == WALK_IDLE);
        map_addr   = spk_axon;
        syn_addr   = ptr_q;
        acc_valid  = (state_q == WALK_BUSY);
        acc_neuron = syn_neuron;
        acc_weight = syn_weight;
        acc_delay  = syn_delay;
    end
endmodule

// File: rtl/sfa_delay_accum.sv
// Delay-slot accumulator: a ring of 2**DLY_W slots per neuron holding
// saturating signed totals. Per cycle it takes at most one accumulation,
// one drain read of the current slot and one timestep pulse. Collisions:
// a same-slot read and add merge into the response; an add into the slot
// being cleared by the pulse starts from zero. Read data is registered.
module sfa_delay_accum #(
    parameter int unsigned NRN_W = 8,
    parameter int unsigned WGT_W = 8,
    parameter int unsigned DLY_W = 3,
    parameter int unsigned ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    acc_valid,
    input  logic [NRN_W-1:0]        acc_neuron,
    input  logic signed [WGT_W-1:0] acc_weight,
    input  logic [DLY_W-1:0]        acc_delay,
    input  logic                    rd_en,
    input  logic [NRN_W-1:0]        rd_neuron,
    output logic                    rd_valid,
    output logic signed [ACC_W-1:0] rd_data,
    output logic [DLY_W-1:0]        cur_slot
);
    localparam int unsigned NUM_NRN = 1 << NRN_W;
    localparam int unsigned ENTRIES = NUM_NRN << DLY_W;
    localparam int unsigned IDX_W   = NRN_W + DLY_W;

    logic signed [ACC_W-1:0] tot_q [ENTRIES];
    logic [DLY_W-1:0]        cur_q;
    logic                    rvld_q;
    logic signed [ACC_W-1:0] rdat_q;

    logic [DLY_W-1:0]        add_slot;
    logic [IDX_W-1:0]        add_idx;
    logic [IDX_W-1:0]        rd_idx;
    logic                    merge;
    logic                    add_from_zero;
    logic signed [ACC_W-1:0] add_base;
    logic signed [ACC_W-1:0] add_sum;
    logic signed [ACC_W-1:0] rd_cur;
    logic signed [ACC_W-1:0] rd_sum;

    // Saturating add of a weight into a total.
    function automatic logic signed [ACC_W-1:0] sat_add(
        input logic signed [ACC_W-1:0] a,
        input logic signed [WGT_W-1:0] b
    );
        logic [ACC_W:0] wide;
        wide = {a[ACC_W-1], a} + {{(ACC_W + 1 - WGT_W){b[WGT_W-1]}}, b};
        if (wide[ACC_W] != wide[ACC_W-1]) begin
            return wide[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}}
                               : {1'b0, {(ACC_W-1){1'b1}}};
        end
        return wide[ACC_W-1:0];
    endfunction

    // Purpose: target entries and collision resolution for this cycle.
    always_comb begin
        add_slot      = cur_q + DLY_W'(tick) + acc_delay;
        add_idx       = {acc_neuron, add_slot};
        rd_idx        = {rd_neuron, cur_q};
        merge         = acc_valid && rd_en && !tick && (add_idx == rd_idx);
        add_from_zero = (rd_en && (rd_idx == add_idx)) || (tick && (add_slot == cur_q));
        add_base      = add_from_zero ? '0 : tot_q[add_idx];
        add_sum       = sat_add(add_base, acc_weight);
        rd_cur        = tot_q[rd_idx];
        rd_sum        = merge ? sat_add(rd_cur, acc_weight) : rd_cur;
    end

    // Purpose: update totals, advance the ring and register the drain reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tot_q[IDX_W'(i)] <= '0;
            end
            cur_q  <= '0;
            rvld_q <= 1'b0;
            rdat_q <= '0;
        end else begin
            rvld_q <= rd_en;
            if (rd_en) begin
                rdat_q        <= rd_sum;
                tot_q[rd_idx] <= '0;
            end
            if (tick) begin
                for (int n = 0; n < NUM_NRN; n++) begin
                    tot_q[{NRN_W'(n), cur_q}] <= '0;
                end
            end
            if (acc_valid && !merge) begin
                tot_q[add_idx] <= add_sum;
            end
            cur_q <= cur_q + DLY_W'(tick);
        end
    end

    // Purpose: drive outputs from registers.
    always_comb begin
        rd_valid = rvld_q;
        rd_data  = rdat_q;
        cur_slot = cur_q;
    end
endmodule

// File: rtl/spike_fanout_accum.sv
// Top: spike fanout with per-synapse delay into ring-buffered dendritic
// totals. Connects the axon map, synapse storage, list walker and the
// delay-slot accumulator. Assumes map writes do not coincide with accepted
// spikes that use the written entry.
module spike_fanout_accum
    import sfa_pkg::*;
#(
    parameter int unsigned AXON_W = SFA_AXON_W,
    parameter int unsigned SYN_AW = SFA_SYN_AW,
    parameter int unsigned NRN_W  = SFA_NRN_W,
    parameter int unsigned WGT_W  = SFA_WGT_W,
    parameter int unsigned DLY_W  = SFA_DLY_W,
    parameter int unsigned ACC_W  = SFA_ACC_W,
    localparam int unsigned CNT_W = SYN_AW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spk_valid,
    output logic                    spk_ready,
    input  logic [AXON_W-1:0]       spk_axon,
    input  logic                    tick,
    input  logic                    rd_en,
    input  logic [NRN_W-1:0]        rd_neuron,
    output logic                    rd_valid,
    output logic signed [ACC_W-1:0] rd_data,
    input  logic                    ax_we,
    input  logic [AXON_W-1:0]       ax_waddr,
    input  logic [SYN_AW-1:0]       ax_wbase,
    input  logic [CNT_W-1:0]        ax_wcount,
    input  logic                    syn_we,
    input  logic [SYN_AW-1:0]       syn_waddr,
    input  logic [NRN_W-1:0]        syn_wneuron,
    input  logic signed [WGT_W-1:0] syn_wweight,
    input  logic [DLY_W-1:0]        syn_wdelay
);
    logic [AXON_W-1:0]       map_addr_w;
    logic [SYN_AW-1:0]       map_base_w;
    logic [CNT_W-1:0]        map_cnt_w;
    logic [SYN_AW-1:0]       syn_addr_w;
    logic [NRN_W-1:0]        syn_nrn_w;
    logic signed [WGT_W-1:0] syn_wgt_w;
    logic [DLY_W-1:0]        syn_dly_w;
    logic                    acc_valid_w;
    logic [NRN_W-1:0]        acc_nrn_w;
    logic signed [WGT_W-1:0] acc_wgt_w;
    logic [DLY_W-1:0]        acc_dly_w;
    logic [DLY_W-1:0]        cur_slot_w;

    sfa_axon_table #(.AXON_W(AXON_W), .SYN_AW(SYN_AW), .CNT_W(CNT_W)) map_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ax_we), .wr_addr(ax_waddr), .wr_base(ax_wbase), .wr_count(ax_wcount),
        .rd_addr(map_addr_w), .rd_base(map_base_w), .rd_count(map_cnt_w)
    );

    sfa_syn_mem #(.SYN_AW(SYN_AW), .NRN_W(NRN_W), .WGT_W(WGT_W), .DLY_W(DLY_W)) syn_i (
        .clk(clk),
        .wr_en(syn_we), .wr_addr(syn_waddr), .wr_neuron(syn_wneuron),
        .wr_weight(syn_wweight), .wr_delay(syn_wdelay),
        .rd_addr(syn_addr_w), .rd_neuron(syn_nrn_w), .rd_weight(syn_wgt_w), .rd_delay(syn_dly_w)
    );

    sfa_fanout_walker #(
        .AXON_W(AXON_W), .SYN_AW(SYN_AW), .CNT_W(CNT_W),
        .NRN_W(NRN_W), .WGT_W(WGT_W), .DLY_W(DLY_W)
    ) walk_i (
        .clk(clk), .rst_n(rst_n),
        .spk_valid(spk_valid), .spk_axon(spk_axon), .spk_ready(spk_ready),
        .map_addr(map_addr_w), .map_base(map_base_w), .map_count(map_cnt_w),
        .syn_addr(syn_addr_w), .syn_neuron(syn_nrn_w), .syn_weight(syn_wgt_w), .syn_delay(syn_dly_w),
        .acc_valid(acc_valid_w), .acc_neuron(acc_nrn_w), .acc_weight(acc_wgt_w), .acc_delay(acc_dly_w)
    );

    sfa_delay_accum #(.NRN_W(NRN_W), .WGT_W(WGT_W), .DLY_W(DLY_W), .ACC_W(ACC_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .acc_valid(acc_valid_w), .acc_neuron(acc_nrn_w), .acc_weight(acc_wgt_w), .acc_delay(acc_dly_w),
        .rd_en(rd_en), .rd_neuron(rd_neuron), .rd_valid(rd_valid), .rd_data(rd_data),
        .cur_slot(cur_slot_w)
    );
endmodule

// File: rtl/sfa_checker.sv
// Checker: temporal properties of the handshake, the walker/accumulator
// hand-off, the drain response and the slot ring. Bound to the top below.
module sfa_checker #(
    parameter int unsigned CNT_W = 11,
    parameter int unsigned DLY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spk_valid,
    input logic             spk_ready,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             tick,
    input logic [CNT_W-1:0] fan_cnt,
    input logic             acc_valid,
    input logic [DLY_W-1:0] cur_slot
);
    // R1: a nonempty list drops ready in the next cycle
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (spk_valid && spk_ready && (fan_cnt != '0)) |=> !spk_ready);

    // R1: an empty list is consumed without leaving idle
    a_r1_empty_list_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (spk_valid && spk_ready && (fan_cnt == '0)) |=> spk_ready);

    // R1: idle with no offer stays idle
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (spk_ready && !spk_valid) |=> spk_ready);

    // R2: accumulations are issued only while a list is being walked
    a_r2_issue_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !spk_ready);

    // R5: every drain request gets a response one cycle later
    a_r5_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R5: no response without a request
    a_r5_no_stray_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R7: a pulse moves the ring by one slot
    a_r7_ring_steps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cur_slot == DLY_W'($past(cur_slot) + 1'b1)));

    // R7: without a pulse the ring stays put
    a_r7_ring_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur_slot));
endmodule

bind spike_fanout_accum sfa_checker #(.CNT_W(CNT_W), .DLY_W(DLY_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .spk_valid(spk_valid), .spk_ready(spk_ready),
    .rd_en(rd_en), .rd_valid(rd_valid), .tick(tick),
    .fan_cnt(map_cnt_w), .acc_valid(acc_valid_w), .cur_slot(cur_slot_w)
);

// File: tb/spike_fanout_accum_tb_top.sv
// Bench: behavioural model (queue of pending contributions, integer totals)
// stepped on every rising edge and compared on every falling edge, plus
// directed checks with hand-computed values for the corner cases.
module spike_fanout_accum_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_N = 256;
    localparam int NUM_S = 8;
    localparam int SYN_D = 1024;

    logic              clk;
    logic              rst_n;
    logic              spk_valid;
    logic              spk_ready;
    logic [7:0]        spk_axon;
    logic              tick;
    logic              rd_en;
    logic [7:0]        rd_neuron;
    logic              rd_valid;
    logic signed [15:0] rd_data;
    logic              ax_we;
    logic [7:0]        ax_waddr;
    logic [9:0]        ax_wbase;
    logic [10:0]       ax_wcount;
    logic              syn_we;
    logic [9:0]        syn_waddr;
    logic [7:0]        syn_wneuron;
    logic signed [7:0] syn_wweight;
    logic [2:0]        syn_wdelay;

    spike_fanout_accum dut_i (
        .clk(clk), .rst_n(rst_n),
        .spk_valid(spk_valid), .spk_ready(spk_ready), .spk_axon(spk_axon),
        .tick(tick), .rd_en(rd_en), .rd_neuron(rd_neuron),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ax_we(ax_we), .ax_waddr(ax_waddr), .ax_wbase(ax_wbase), .ax_wcount(ax_wcount),
        .syn_we(syn_we), .syn_waddr(syn_waddr), .syn_wneuron(syn_wneuron),
        .syn_wweight(syn_wweight), .syn_wdelay(syn_wdelay)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model state
    typedef struct { int n; int w; int d; } contrib_t;
    contrib_t pend[$];
    int  m_base [256];
    int  m_cnt  [256];
    int  m_nrn  [SYN_D];
    int  m_wgt  [SYN_D];
    int  m_dly  [SYN_D];
    int  m_tot  [NUM_N][NUM_S];
    int  m_cur;
    bit  exp_ready;
    bit  exp_rvld;
    int  exp_rdat;

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // model step at each rising edge, from the bench-driven inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete();
            for (int n = 0; n < NUM_N; n++)
                for (int s = 0; s < NUM_S; s++) m_tot[n][s] = 0;
            m_cur     = 0;
            exp_ready = 1;
            exp_rvld  = 0;
            exp_rdat  = 0;
        end else begin
            contrib_t c;
            bit av;
            bit mg;
            int sa;
            av = 0;
            c  = '{n: 0, w: 0, d: 0};
            if (pend.size() > 0) begin
                c  = pend.pop_front();
                av = 1;
            end else if (spk_valid) begin
                for (int i = 0; i < m_cnt[spk_axon]; i++) begin
                    int a;
                    a = (m_base[spk_axon] + i) % SYN_D;
                    pend.push_back('{n: m_nrn[a], w: m_wgt[a], d: m_dly[a]});
                end
            end
            sa = (m_cur + int'(tick) + c.d) % NUM_S;
            mg = av && rd_en && !tick && (c.n == int'(rd_neuron)) && (sa == m_cur);
            exp_rvld = rd_en;
            if (rd_en) begin
                exp_rdat = sat16(m_tot[rd_neuron][m_cur] + (mg ? c.w : 0));
                m_tot[rd_neuron][m_cur] = 0;
            end
            if (tick)
                for (int n = 0; n < NUM_N; n++) m_tot[n][m_cur] = 0;
            if (av && !mg) m_tot[c.n][sa] = sat16(m_tot[c.n][sa] + c.w);
            m_cur = (m_cur + int'(tick)) % NUM_S;
            exp_ready = (pend.size() == 0);
        end
    end

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1", "spk_ready vs model", int'(spk_ready), int'(exp_ready));
            check("R5", "rd_valid vs model", int'(rd_valid), int'(exp_rvld));
            if (exp_rvld) check("R5", "rd_data vs model", int'(rd_data), exp_rdat);
        end
    end

    task automatic cyc(input bit sv, input int sa, input bit tk, input bit re, input int rn);
        spk_valid = sv;
        spk_axon  = 8'(sa);
        tick      = tk;
        rd_en     = re;
        rd_neuron = 8'(rn);
        @(negedge clk);
        spk_valid = 0;
        tick      = 0;
        rd_en     = 0;
    endtask

    task automatic wait_ready();
        while (!spk_ready) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic spike(input int a);
        cyc(1, a, 0, 0, 0);
        wait_ready();
    endtask

    task automatic ticks(input int k);
        repeat (k) cyc(0, 0, 1, 0, 0);
    endtask

    task automatic read_expect(input string req, input int n, input int exp);
        cyc(0, 0, 0, 1, n);
        check(req, $sformatf("drain neuron %0d", n), int'(rd_data), exp);
    endtask

    task automatic write_axon(input int a, input int b, input int c);
        ax_we = 1; ax_waddr = 8'(a); ax_wbase = 10'(b); ax_wcount = 11'(c);
        @(negedge clk);
        ax_we = 0;
        m_base[a] = b;
        m_cnt[a]  = c;
    endtask

    task automatic write_syn(input int a, input int n, input int w, input int d);
        syn_we = 1; syn_waddr = 10'(a); syn_wneuron = 8'(n);
        syn_wweight = 8'(w); syn_wdelay = 3'(d);
        @(negedge clk);
        syn_we = 0;
        m_nrn[a] = n;
        m_wgt[a] = w;
        m_dly[a] = d;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin m_base[i] = 0; m_cnt[i] = 0; end
        rst_n = 0; spk_valid = 0; spk_axon = 0; tick = 0; rd_en = 0; rd_neuron = 0;
        ax_we = 0; ax_waddr = 0; ax_wbase = 0; ax_wcount = 0;
        syn_we = 0; syn_waddr = 0; syn_wneuron = 0; syn_wweight = 0; syn_wdelay = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9: reset state
        check("R9", "spk_ready after reset", int'(spk_ready), 1);
        check("R9", "rd_valid after reset", int'(rd_valid), 0);
        read_expect("R9", 5, 0);

        // R2 R3: three-entry list with delays 0,1,2 (slot 0 current)
        write_syn(10, 1, 5, 0);
        write_syn(11, 2, -3, 1);
        write_syn(12, 1, 7, 2);
        write_axon(3, 10, 3);
        cyc(1, 3, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            check("R1", "ready low during walk", int'(spk_ready), 0);
            cyc(0, 0, 0, 0, 0);
        end
        check("R1", "ready back after walk", int'(spk_ready), 1);
        read_expect("R3", 1, 5);
        read_expect("R3", 2, 0);
        ticks(1);
        read_expect("R3", 2, -3);
        ticks(1);
        read_expect("R3", 1, 7);

        // R1: zero-count axon keeps ready high
        cyc(1, 7, 0, 0, 0);
        check("R1", "ready after empty list", int'(spk_ready), 1);

        // R2: list wrapping past the top of synapse storage (slot 2)
        write_syn(1022, 4, 1, 0);
        write_syn(1023, 4, 2, 0);
        write_syn(0, 4, 4, 0);
        write_axon(9, 1022, 3);
        spike(9);
        read_expect("R2", 4, 7);

        // R4: positive and negative saturation
        for (int i = 0; i < 300; i++) write_syn(100 + i, 9, 127, 0);
        for (int i = 0; i < 300; i++) write_syn(400 + i, 9, -128, 0);
        write_axon(20, 100, 300);
        write_axon(21, 400, 300);
        spike(20);
        read_expect("R4", 9, 32767);
        spike(21);
        read_expect("R4", 9, -32768);

        // R6: drain and add to the same entry in one cycle
        write_syn(700, 11, 9, 0);
        write_syn(701, 11, 4, 0);
        write_axon(30, 700, 1);
        write_axon(31, 701, 1);
        spike(31);
        cyc(1, 30, 0, 0, 0);
        cyc(0, 0, 0, 1, 11);
        check("R6", "merged drain", int'(rd_data), 13);
        read_expect("R6", 11, 0);

        // R7: drain in a pulse cycle sees the pre-clear total (slot 2 -> 3)
        spike(31);
        cyc(0, 0, 1, 1, 11);
        check("R7", "drain during pulse", int'(rd_data), 4);
        read_expect("R7", 11, 0);
        // R7: an undrained total is cleared by the pulse (slot 3)
        spike(31);
        ticks(8);
        read_expect("R7", 11, 0);

        // R8: delay 7 in a pulse cycle lands in the slot being cleared
        write_syn(710, 14, 3, 0);
        write_syn(711, 14, 5, 7);
        write_axon(40, 710, 2);
        cyc(1, 40, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        read_expect("R8", 14, 0);
        ticks(7);
        read_expect("R8", 14, 5);
        // R8: delay 0 in a pulse cycle lands in the new current slot
        write_syn(712, 15, 2, 0);
        write_axon(41, 712, 1);
        cyc(1, 41, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        read_expect("R8", 15, 2);

        // R10: rewritten entry takes effect for the next spike
        write_syn(10, 1, 11, 0);
        spike(3);
        read_expect("R10", 1, 11);

        cyc(0, 0, 0, 0, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: actual still running, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule